// File: doc/BRIEF.md
# I2C Target Receive Byte Buffer

This block is the receive-side data store of an I2C target. A byte-level protocol engine hands it each completed data byte with a one-cycle strobe, and it also signals when a new transaction opens with this target's address and the write direction. On the other side, a CPU register interface pops bytes one at a time through a read strobe on the data-in register and polls an empty flag, reading until the flag is 1.

Storage is a two-byte FIFO followed by a one-byte holding (shift) register. When a byte arrives and the FIFO already holds two bytes, the byte is parked in the holding register and a sticky write-event interrupt flag is raised. While a byte is parked, a hold output tells the engine to stretch the clock rather than deliver another byte. The first CPU pop that frees a slot moves the parked byte into the FIFO. A new write transaction never discards unread bytes. Only the synchronous reset discards the contents.

Top module: `i2c_rx_buffer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block empties the FIFO and the holding register and clears the interrupt flag. After that edge `rx_empty` is 1, `hold` is 0, `wr_irq` is 0 and `rd_data` is 0.
- R2: Bytes come out in the order they arrived, one per `rd_strobe` on a non-empty FIFO. The popped byte appears on `rd_data` after the next rising edge and stays there until the next successful pop.
- R3: `rx_empty` is 1 exactly when the FIFO holds no bytes. It does not count the holding register, which can only be occupied while the FIFO is full.
- R4: The FIFO holds at most two bytes. A byte that arrives (`byte_valid` with `hold` low) while two bytes are stored and no pop occurs in that cycle is kept in the holding register, and `hold` is 1 from the next edge.
- R5: A pop while `hold` is 1 moves the parked byte to the tail of the FIFO in the same edge. `hold` returns to 0 and the FIFO stays at two bytes, still in arrival order.
- R6: A byte that arrives while the FIFO holds two bytes sets `wr_irq` at the next edge. A byte that arrives while the FIFO holds fewer than two bytes does not set it.
- R7: `wr_irq` stays 1 until a cycle with `irq_clr` high, which clears it at the next edge. If a set and a clear fall in the same cycle, the flag ends up 1.
- R8: `rd_strobe` while `rx_empty` is 1 leaves `rd_data`, `rx_empty` and `hold` unchanged.
- R9: `addr_wr_match` (a new start with this target's address and the write direction) flushes nothing. Unread bytes, `rx_empty` and `hold` keep their values.
- R10: `byte_valid` while `hold` is 1 is ignored. That byte never appears on `rd_data`, and it neither changes state nor sets `wr_irq`.
- R11: If a byte arrives while two bytes are stored and a pop happens in the same cycle, the byte goes straight into the FIFO and `hold` stays 0. `wr_irq` is still set under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: protocol engine has completed a received byte |
| byte_data | input | DATA_W | Received byte, valid with `byte_valid` |
| addr_wr_match | input | 1 | One-cycle strobe: start plus own address with write direction seen |
| rd_strobe | input | 1 | CPU read of the data-in register (pop) |
| rd_data | output | DATA_W | Last byte popped by the CPU |
| rx_empty | output | 1 | 1 when the FIFO holds no bytes |
| hold | output | 1 | 1 while a byte is parked in the holding register; engine should stretch |
| irq_clr | input | 1 | Write-one-to-clear strobe for `wr_irq` |
| wr_irq | output | 1 | Sticky write-event interrupt flag |

## Verification
The bench aims at the moment the third byte lands on a full FIFO. A design that dropped that byte or overwrote the FIFO tail would lose or reorder data in the read-out, and one that forgot the hold output would let the engine overrun. It also hits a pop in the same cycle as a full arrival, a set and a clear of the interrupt in the same cycle, and reads from an empty FIFO. A design that flushed on a new write address, popped garbage on an empty read, or let a clear beat a set would show a wrong `rd_data`, a spurious `rx_empty` or a missing interrupt. A byte strobed while `hold` is high must vanish without trace, and a design that accepted it would show an extra byte in the read-out.

// File: rtl/rxb_pkg.sv
// Package: shared defaults for the I2C target receive buffer.
// Assumes: byte-wide data path and a two-entry FIFO unless overridden.
package rxb_pkg;
    localparam int RXB_DATA_W = 8;
    localparam int RXB_DEPTH  = 2;
endpackage

// File: rtl/rxb_fifo.sv
// Module: rxb_fifo
// A small circular FIFO of DEPTH entries. It accepts a push and a pop in the
// same cycle, including a push while full when a pop frees the head.
// Assumes: the caller never pushes while full without a pop, and never pops
// while empty. Both are checked by assertions.
module rxb_fifo #(
    parameter int DATA_W = rxb_pkg::RXB_DATA_W,
    parameter int DEPTH  = rxb_pkg::RXB_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [DEPTH-1:0][DATA_W-1:0] slots;

    // One storage register per entry, written when the write pointer selects it.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin : p_slot_write
            if (!rst_n)
                q <= '0;
            else if (push && (wr_ptr == PTR_W'(gi)))
                q <= push_data;
        end
        assign slots[gi] = q;
    end

    // Advance the write pointer on each push, wrapping at the last entry.
    always_ff @(posedge clk) begin : p_wr_ptr
        if (!rst_n)
            wr_ptr <= '0;
        else if (push)
            wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each pop, wrapping at the last entry.
    always_ff @(posedge clk) begin : p_rd_ptr
        if (!rst_n)
            rd_ptr <= '0;
        else if (pop)
            rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end

    // Track occupancy; a simultaneous push and pop leave it unchanged.
    always_ff @(posedge clk) begin : p_count
        if (!rst_n)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop)
        else $error("FIFO pushed while full without a pop");

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("FIFO popped while empty");

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT)
        else $error("FIFO occupancy beyond depth");
endmodule

// File: rtl/rxb_park.sv
// Module: rxb_park
// A one-entry holding register for a byte that arrived while the FIFO was full.
// Assumes: load and release never occur together, and load only happens while
// the register is free.
module rxb_park #(
    parameter int DATA_W = rxb_pkg::RXB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              release_i,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    // Occupancy bit: set on load, cleared when the byte moves into the FIFO.
    always_ff @(posedge clk) begin : p_valid
        if (!rst_n)
            valid <= 1'b0;
        else if (load)
            valid <= 1'b1;
        else if (release_i)
            valid <= 1'b0;
    end

    // Capture the parked byte.
    always_ff @(posedge clk) begin : p_data
        if (!rst_n)
            data <= '0;
        else if (load)
            data <= load_data;
    end

    assert_park_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid)
        else $error("holding register loaded while occupied");

    assert_release_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> valid)
        else $error("holding register released while empty");
endmodule

// File: rtl/rxb_irq.sv
// Module: rxb_irq
// Sticky interrupt flag with a write-one-to-clear strobe; a set beats a clear.
// Assumes: set and clr are single-cycle qualified strobes.
module rxb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until cleared; a set in the same cycle wins.
    always_ff @(posedge clk) begin : p_flag
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag)
        else $error("interrupt flag dropped without a clear");

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag)
        else $error("interrupt set lost");

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag)
        else $error("interrupt clear ignored");
endmodule

// File: rtl/i2c_rx_buffer.sv
// Module: i2c_rx_buffer
// Receive byte buffer of an I2C target: a two-entry FIFO, a one-byte holding
// register for a byte that lands on a full FIFO, a registered data-in read
// port and a sticky write-event interrupt.
// Assumes: the protocol engine stretches the clock while hold is 1. A byte
// strobed in that state is ignored. A new write transaction never flushes data.
module i2c_rx_buffer #(
    parameter int DATA_W = rxb_pkg::RXB_DATA_W,
    parameter int DEPTH  = rxb_pkg::RXB_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              addr_wr_match,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              hold,
    input  logic              irq_clr,
    output logic              wr_irq
);
    logic              fifo_push;
    logic [DATA_W-1:0] fifo_push_data;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_full;
    logic              fifo_empty;
    logic              park_valid;
    logic [DATA_W-1:0] park_data;
    logic              park_load;
    logic              park_release;
    logic              arrive;
    logic              arrive_full;

    // Steer arrivals, pops and parked-byte moves between FIFO and holding register.
    always_comb begin : p_steer
        fifo_pop       = rd_strobe && !fifo_empty;
        arrive         = byte_valid && !park_valid;
        arrive_full    = arrive && fifo_full;
        park_load      = arrive_full && !fifo_pop;
        park_release   = park_valid && fifo_pop;
        fifo_push      = (arrive && !park_load) || park_release;
        fifo_push_data = park_valid ? park_data : byte_data;
    end

    rxb_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_push_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    rxb_park #(
        .DATA_W (DATA_W)
    ) u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (park_load),
        .load_data (byte_data),
        .release_i (park_release),
        .valid     (park_valid),
        .data      (park_data)
    );

    rxb_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (arrive_full),
        .clr   (irq_clr),
        .flag  (wr_irq)
    );

    // Data-in register: capture the FIFO head on each successful pop.
    always_ff @(posedge clk) begin : p_rd_data
        if (!rst_n)
            rd_data <= '0;
        else if (fifo_pop)
            rd_data <= fifo_head;
    end

    assign rx_empty = fifo_empty;
    assign hold     = park_valid;

    assert_park_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !hold && !rx_empty && fifo_full && !rd_strobe) |=> hold)
        else $error("byte on full FIFO not parked");

    assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && rd_strobe) |=> (!hold && !rx_empty))
        else $error("parked byte not moved on pop");

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rx_empty) |=> $stable(rd_data))
        else $error("read of empty FIFO changed data");

    assert_no_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr_match && !rd_strobe && !byte_valid) |=> ($stable(rx_empty) && $stable(hold)))
        else $error("new write transaction disturbed the buffer");

    assert_hold_implies_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> fifo_full)
        else $error("holding register occupied while FIFO not full");
endmodule

// File: tb/tb_i2c_rx_buffer.sv
// Bench for i2c_rx_buffer: directed corner cases followed by seeded random
// traffic. Each cycle is compared against a bench-side reference model.
module tb_i2c_rx_buffer;
    localparam int  DATA_W    = 8;
    localparam time CLK_PER   = 10ns;
    localparam int  WATCHDOG  = 50000;
    localparam int  RAND_CYC  = 4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              addr_wr_match = 1'b0;
    logic              rd_strobe = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rx_empty;
    logic              hold;
    logic              irq_clr = 1'b0;
    logic              wr_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [DATA_W-1:0] mq[$];
    bit                m_pv = 1'b0;
    logic [DATA_W-1:0] m_pd = '0;
    logic [DATA_W-1:0] m_rd = '0;
    bit                m_irq = 1'b0;

    i2c_rx_buffer #(.DATA_W(DATA_W), .DEPTH(2)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .addr_wr_match (addr_wr_match),
        .rd_strobe     (rd_strobe),
        .rd_data       (rd_data),
        .rx_empty      (rx_empty),
        .hold          (hold),
        .irq_clr       (irq_clr),
        .wr_irq        (wr_irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic bit irq_next(bit cur, bit set_i, bit clr_i);
        if (set_i) return 1'b1;
        if (clr_i) return 1'b0;
        return cur;
    endfunction

    // Advance the model by one edge using the inputs currently driven.
    task automatic model_step(bit bv, logic [DATA_W-1:0] bd, bit rs, bit clr);
        bit pop = rs && (mq.size() > 0);
        bit arr = bv && !m_pv;
        bit full = (mq.size() == 2);
        if (pop) begin
            m_rd = mq[0];
            void'(mq.pop_front());
        end
        if (m_pv && pop) begin
            mq.push_back(m_pd);
            m_pv = 1'b0;
        end
        if (arr) begin
            if (full && !pop) begin
                m_pv = 1'b1;
                m_pd = bd;
            end else begin
                mq.push_back(bd);
            end
        end
        m_irq = irq_next(m_irq, arr && full, clr);
    endtask

    task automatic check1(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FIFO-BUF FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all(string tag);
        check1(tag, "rd_data",  int'(rd_data),  int'(m_rd));
        check1(tag, "rx_empty", int'(rx_empty), int'(mq.size() == 0));
        check1(tag, "hold",     int'(hold),     int'(m_pv));
        check1(tag, "wr_irq",   int'(wr_irq),   int'(m_irq));
    endtask

    // One cycle: drive at the falling edge, step the model, compare at the next falling edge.
    task automatic cyc1(string tag, bit bv, logic [DATA_W-1:0] bd, bit rs, bit clr, bit am);
        byte_valid    = bv;
        byte_data     = bd;
        rd_strobe     = rs;
        irq_clr       = clr;
        addr_wr_match = am;
        model_step(bv, bd, rs, clr);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            n_chk++;
            n_bad++;
            $display("FIFO-BUF FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare_all("R1");
        check1("R1", "rd_data zero", int'(rd_data), 0);

        // R2 / R3: two bytes in, read back in order
        cyc1("R3", 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0);
        check1("R3", "not empty after one byte", int'(rx_empty), 0);
        cyc1("R2", 1'b1, 8'hB2, 1'b0, 1'b0, 1'b0);
        check1("R6", "no irq with room", int'(wr_irq), 0);
        cyc1("R2", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R2", "first byte out", int'(rd_data), 8'hA1);
        cyc1("R2", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R2", "second byte out", int'(rd_data), 8'hB2);
        check1("R3", "empty after draining", int'(rx_empty), 1);

        // R8: reads of an empty FIFO
        cyc1("R8", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        cyc1("R8", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R8", "rd_data kept", int'(rd_data), 8'hB2);

        // R4 / R6 / R10: third byte parks, further byte ignored
        cyc1("R4", 1'b1, 8'h11, 1'b0, 1'b0, 1'b0);
        cyc1("R4", 1'b1, 8'h22, 1'b0, 1'b0, 1'b0);
        cyc1("R4", 1'b1, 8'h33, 1'b0, 1'b0, 1'b0);
        check1("R4", "hold after third byte", int'(hold), 1);
        check1("R6", "irq on full arrival", int'(wr_irq), 1);
        cyc1("R10", 1'b1, 8'h44, 1'b0, 1'b0, 1'b0);
        cyc1("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check1("R9", "hold kept across new write", int'(hold), 1);

        // R5: pop moves parked byte in; order kept; ignored byte absent
        cyc1("R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R5", "hold released", int'(hold), 0);
        check1("R5", "first popped", int'(rd_data), 8'h11);
        cyc1("R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R5", "second popped", int'(rd_data), 8'h22);
        cyc1("R10", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R10", "parked byte, not ignored one", int'(rd_data), 8'h33);
        check1("R10", "nothing left", int'(rx_empty), 1);

        // R7: clear alone
        cyc1("R7", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check1("R7", "cleared", int'(wr_irq), 0);

        // R11 / R7: full arrival with pop and clear in same cycle
        cyc1("R11", 1'b1, 8'h55, 1'b0, 1'b0, 1'b0);
        cyc1("R11", 1'b1, 8'h66, 1'b0, 1'b0, 1'b0);
        cyc1("R11", 1'b1, 8'h77, 1'b1, 1'b1, 1'b0);
        check1("R11", "no park when popping", int'(hold), 0);
        check1("R7", "set beats clear", int'(wr_irq), 1);
        check1("R11", "popped head", int'(rd_data), 8'h55);

        // R9: new write transaction keeps unread bytes
        cyc1("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        cyc1("R9", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check1("R9", "byte survives new write", int'(rd_data), 8'h66);
        cyc1("R9", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
        check1("R9", "last byte", int'(rd_data), 8'h77);

        // R2: seeded random traffic against the model
        for (int i = 0; i < RAND_CYC; i++) begin
            cyc1("R2",
                 ($urandom % 3) == 0,
                 DATA_W'($urandom),
                 ($urandom % 3) == 0,
                 ($urandom % 8) == 0,
                 ($urandom % 16) == 0);
        end

        // R1: reset mid-traffic discards contents
        byte_valid = 1'b1; byte_data = 8'h99; rd_strobe = 1'b0; irq_clr = 1'b0; addr_wr_match = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        rst_n = 1'b1;
        mq.delete();
        m_pv = 1'b0; m_pd = '0; m_rd = '0; m_irq = 1'b0;
        compare_all("R1");

        finish_run();
    end
endmodule